// File: doc/BRIEF.md
# Byte/Word ALU Status Flag Generator

This block produces the arithmetic and logical result of a small set of integer operations, together with the six status flags that go with it: carry, parity, auxiliary (nibble) carry, zero, sign and signed overflow. A size input selects byte or word operation. In byte mode only the low half of each operand is used, and every flag refers to the low byte. In word mode the flags refer to the full 16-bit width. The two exceptions are parity, which always looks at the low byte of the result, and the auxiliary carry, which always looks at bit 3.

An execution stage drives the operands, an operation code, the carry flag currently held and the size bit. It receives the result, the new flags and a write-back enable. The write-back enable is low for compare and test, which only update flags. The datapath is combinational. A parameter `OUT_REG` (default 1) places a register with asynchronous active-low reset on all outputs.

Top module: `alu_sf_top`

## Requirements
- R1: Operation codes on `op_i` are 0 add, 1 add-with-carry, 2 subtract, 3 subtract-with-borrow, 4 increment, 5 decrement, 6 compare, 7 AND, 8 OR, 9 XOR and 10 test. Add-with-carry and subtract-with-borrow use `cin_i` as carry-in or borrow-in; add, subtract and compare ignore it. The result is the arithmetic value modulo 2^8 (`word_i`=0) or 2^16 (`word_i`=1).
- R2: For add and subtract type operations, `cf_o` is the carry out of, or the borrow into, the top bit of the selected size (bit 7 or bit 15).
- R3: For arithmetic operations, `af_o` is the carry out of, or the borrow into, bit 3.
- R4: `zf_o` is 1 exactly when every bit of the selected-size result is zero. `sf_o` equals bit 7 (byte mode) or bit 15 (word mode) of the result.
- R5: `pf_o` is 1 when bits 7..0 of the result hold an even number of ones, in both byte and word mode.
- R6: `of_o` is the signed overflow. For additions it is 1 when both operands have the same sign and the result sign differs from it. For subtractions it is 1 when the operand signs differ and the result sign differs from the first operand.
- R7: Increment and decrement compute `a_i`+1 and `a_i`-1 and set OF, SF, ZF, AF and PF. `cf_o` equals `cin_i` for these operations.
- R8: AND, OR, XOR and test produce the bitwise result and force `cf_o`, `of_o` and `af_o` to 0, whatever `cin_i` is.
- R9: Compare gives the same result and flags as subtract. `wb_o` is 0 for compare and test and 1 for all other valid codes.
- R10: In byte mode, `res_o[15:8]` is 0.
- R11: With `OUT_REG`=1, all outputs are 0 while `rst_ni` is low. The outputs reflect the inputs sampled at the previous rising edge of `clk_i`.
- R12: Codes 11 to 15 produce a zero result, all flags 0 and `wb_o`=0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock for the optional output register |
| rst_ni | input | 1 | Asynchronous active-low reset |
| op_i | input | 4 | Operation code |
| word_i | input | 1 | 1 selects word size, 0 selects byte size |
| a_i | input | 16 | First operand |
| b_i | input | 16 | Second operand |
| cin_i | input | 1 | Incoming carry flag |
| res_o | output | 16 | Result |
| cf_o | output | 1 | Carry/borrow flag |
| pf_o | output | 1 | Parity flag (low byte) |
| af_o | output | 1 | Auxiliary carry from bit 3 |
| zf_o | output | 1 | Zero flag |
| sf_o | output | 1 | Sign flag |
| of_o | output | 1 | Signed overflow flag |
| wb_o | output | 1 | Result write-back enable |

## Verification
A wrong nibble-carry chain shows up in the same cycle as a wrong `res_o` or a wrong `af_o`/`cf_o`. Which output is affected depends on the boundary where the error sits: bit 3, bit 7 or bit 15. A mistake in the size select shows as an upper byte that leaks through, or as a sign or carry flag taken from the wrong bit. This is visible one edge after the stimulus. Because the block holds no state beyond the output register, every fault appears on the item that triggers it. The stimulus therefore targets the carry boundaries in each mode, signed limits, and the operations that preserve or clear flags.

// File: rtl/alu_sf_pkg.sv
package alu_sf_pkg;
  localparam int unsigned OP_W = 4;

  typedef enum logic [OP_W-1:0] {
    OP_ADD  = 4'd0,
    OP_ADC  = 4'd1,
    OP_SUB  = 4'd2,
    OP_SBB  = 4'd3,
    OP_INC  = 4'd4,
    OP_DEC  = 4'd5,
    OP_CMP  = 4'd6,
    OP_AND  = 4'd7,
    OP_OR   = 4'd8,
    OP_XOR  = 4'd9,
    OP_TEST = 4'd10
  } alu_op_e;

  typedef enum logic [1:0] {
    LF_AND = 2'd0,
    LF_OR  = 2'd1,
    LF_XOR = 2'd2
  } lgc_fn_e;

  typedef struct packed {
    logic cf;
    logic pf;
    logic af;
    logic zf;
    logic sf;
    logic of;
  } alu_flags_t;

  typedef struct packed {
    logic    valid;
    logic    arith;
    logic    sub;
    logic    use_one;
    logic    use_cin;
    logic    keep_cf;
    logic    wb;
    lgc_fn_e lfn;
  } alu_ctl_t;
endpackage

// File: rtl/alu_sf_decode.sv
module alu_sf_decode
  import alu_sf_pkg::*;
(
  input  logic [OP_W-1:0] op_i,
  output alu_ctl_t        ctl_o
);
  always_comb begin
    ctl_o = '{valid: 1'b1, arith: 1'b1, sub: 1'b0, use_one: 1'b0,
              use_cin: 1'b0, keep_cf: 1'b0, wb: 1'b1, lfn: LF_AND};
    unique case (op_i)
      OP_ADD: ;
      OP_ADC: ctl_o.use_cin = 1'b1;
      OP_SUB: ctl_o.sub = 1'b1;
      OP_SBB: begin
        ctl_o.sub     = 1'b1;
        ctl_o.use_cin = 1'b1;
      end
      OP_INC: begin
        ctl_o.use_one = 1'b1;
        ctl_o.keep_cf = 1'b1;
      end
      OP_DEC: begin
        ctl_o.sub     = 1'b1;
        ctl_o.use_one = 1'b1;
        ctl_o.keep_cf = 1'b1;
      end
      OP_CMP: begin
        ctl_o.sub = 1'b1;
        ctl_o.wb  = 1'b0;
      end
      OP_AND: ctl_o.arith = 1'b0;
      OP_OR: begin
        ctl_o.arith = 1'b0;
        ctl_o.lfn   = LF_OR;
      end
      OP_XOR: begin
        ctl_o.arith = 1'b0;
        ctl_o.lfn   = LF_XOR;
      end
      OP_TEST: begin
        ctl_o.arith = 1'b0;
        ctl_o.wb    = 1'b0;
      end
      default: begin
        ctl_o.valid = 1'b0;
        ctl_o.arith = 1'b0;
        ctl_o.wb    = 1'b0;
      end
    endcase
  end
endmodule

// File: rtl/alu_sf_addsub.sv
module alu_sf_addsub #(
  parameter int unsigned DATA_W = 16
) (
  input  logic [DATA_W-1:0]   a_i,
  input  logic [DATA_W-1:0]   y_i,   // already inverted for subtraction
  input  logic                c0_i,
  output logic [DATA_W-1:0]   sum_o,
  output logic [DATA_W/4:0]   nib_c_o
);
  localparam int unsigned NIB_N = DATA_W / 4;

  assign nib_c_o[0] = c0_i;

  // nibble-sliced ripple so carries at bit 3 and 7 are exposed
  for (genvar i = 0; i < NIB_N; i++) begin : g_nib
    logic [4:0] part;
    assign part = {1'b0, a_i[i*4 +: 4]} + {1'b0, y_i[i*4 +: 4]} + {4'd0, nib_c_o[i]};
    assign sum_o[i*4 +: 4] = part[3:0];
    assign nib_c_o[i+1]    = part[4];
  end
endmodule

// File: rtl/alu_sf_logic.sv
module alu_sf_logic
  import alu_sf_pkg::*;
#(
  parameter int unsigned DATA_W = 16
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  lgc_fn_e           fn_i,
  output logic [DATA_W-1:0] res_o
);
  always_comb begin
    unique case (fn_i)
      LF_OR:   res_o = a_i | b_i;
      LF_XOR:  res_o = a_i ^ b_i;
      default: res_o = a_i & b_i;
    endcase
  end
endmodule

// File: rtl/alu_sf_flags.sv
module alu_sf_flags
  import alu_sf_pkg::*;
#(
  parameter int unsigned DATA_W = 16
) (
  input  alu_ctl_t            ctl_i,
  input  logic                word_i,
  input  logic                cin_i,
  input  logic [DATA_W-1:0]   a_i,
  input  logic [DATA_W-1:0]   y_i,
  input  logic [DATA_W-1:0]   sum_i,
  input  logic [DATA_W/4:0]   nib_c_i,
  input  logic [DATA_W-1:0]   lgc_i,
  output logic [DATA_W-1:0]   res_o,
  output alu_flags_t          flg_o
);
  localparam int unsigned HALF_W = DATA_W / 2;
  localparam int unsigned NIB_N  = DATA_W / 4;

  logic [DATA_W-1:0] full;
  logic              a_s, y_s, r_s, c_top;

  assign full  = ctl_i.arith ? sum_i : lgc_i;
  assign a_s   = word_i ? a_i[DATA_W-1] : a_i[HALF_W-1];
  assign y_s   = word_i ? y_i[DATA_W-1] : y_i[HALF_W-1];
  assign c_top = word_i ? nib_c_i[NIB_N] : nib_c_i[NIB_N/2];

  always_comb begin
    res_o = '0;
    if (ctl_i.valid) begin
      res_o[HALF_W-1:0] = full[HALF_W-1:0];
      if (word_i) res_o[DATA_W-1:HALF_W] = full[DATA_W-1:HALF_W];
    end
  end

  assign r_s = word_i ? res_o[DATA_W-1] : res_o[HALF_W-1];

  always_comb begin
    flg_o = '0;
    if (ctl_i.valid) begin
      flg_o.zf = (res_o == '0);
      flg_o.sf = r_s;
      flg_o.pf = ~^res_o[HALF_W-1:0];
      if (ctl_i.arith) begin
        flg_o.af = nib_c_i[1] ^ ctl_i.sub;
        flg_o.of = (a_s == y_s) && (r_s != a_s);
        flg_o.cf = ctl_i.keep_cf ? cin_i : (c_top ^ ctl_i.sub);
      end
    end
  end
endmodule

// File: rtl/alu_sf_top.sv
module alu_sf_top
  import alu_sf_pkg::*;
#(
  parameter int unsigned DATA_W  = 16,
  parameter bit          OUT_REG = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [3:0]        op_i,
  input  logic              word_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic              cin_i,
  output logic [DATA_W-1:0] res_o,
  output logic              cf_o,
  output logic              pf_o,
  output logic              af_o,
  output logic              zf_o,
  output logic              sf_o,
  output logic              of_o,
  output logic              wb_o
);
  localparam int unsigned HALF_W = DATA_W / 2;
  localparam int unsigned NIB_N  = DATA_W / 4;

  alu_ctl_t          ctl;
  logic [DATA_W-1:0] b_eff, y, sum, lgc, res_c;
  logic [NIB_N:0]    nib_c;
  logic              c_in_eff;
  alu_flags_t        flg_c;

  alu_sf_decode u_dec (.op_i(op_i), .ctl_o(ctl));

  assign b_eff    = ctl.use_one ? DATA_W'(1) : b_i;
  assign y        = ctl.sub ? ~b_eff : b_eff;
  assign c_in_eff = (ctl.use_cin & cin_i) ^ ctl.sub;

  alu_sf_addsub #(.DATA_W(DATA_W)) u_add (
    .a_i(a_i), .y_i(y), .c0_i(c_in_eff), .sum_o(sum), .nib_c_o(nib_c)
  );

  alu_sf_logic #(.DATA_W(DATA_W)) u_lgc (
    .a_i(a_i), .b_i(b_i), .fn_i(ctl.lfn), .res_o(lgc)
  );

  alu_sf_flags #(.DATA_W(DATA_W)) u_flg (
    .ctl_i(ctl), .word_i(word_i), .cin_i(cin_i), .a_i(a_i), .y_i(y),
    .sum_i(sum), .nib_c_i(nib_c), .lgc_i(lgc), .res_o(res_c), .flg_o(flg_c)
  );

  if (OUT_REG) begin : g_oreg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        res_o <= '0;
        {cf_o, pf_o, af_o, zf_o, sf_o, of_o} <= '0;
        wb_o  <= 1'b0;
      end else begin
        res_o <= res_c;
        {cf_o, pf_o, af_o, zf_o, sf_o, of_o} <= flg_c;
        wb_o  <= ctl.wb;
      end
    end
  end else begin : g_comb
    assign res_o = res_c;
    assign {cf_o, pf_o, af_o, zf_o, sf_o, of_o} = flg_c;
    assign wb_o  = ctl.wb;
  end

  // R1: adding zero with no carry returns the operand in the selected size
  a_r1_add_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == OP_ADD && b_i == '0) |->
      (res_c[HALF_W-1:0] == a_i[HALF_W-1:0] && !flg_c.cf && !flg_c.af));

  a_r4_zero_consistent: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flg_c.zf |-> (!flg_c.sf && flg_c.pf));

  a_r7_incdec_keep_cf: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == OP_INC || op_i == OP_DEC) |-> (flg_c.cf == cin_i));

  a_r8_logic_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i inside {OP_AND, OP_OR, OP_XOR, OP_TEST}) |->
      (!flg_c.cf && !flg_c.of && !flg_c.af));

  a_r9_no_writeback: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == OP_CMP || op_i == OP_TEST) |-> !ctl.wb);

  a_r10_byte_hi_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !word_i |-> (res_c[DATA_W-1:HALF_W] == '0));

  a_r12_bad_op_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i > OP_TEST) |-> (res_c == '0 && flg_c == '0 && !ctl.wb));
endmodule

// File: tb/tb_alu_sf_top.sv
module tb_alu_sf_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [3:0]  op_i = '0;
  logic        word_i = 1'b0;
  logic [15:0] a_i = '0, b_i = '0;
  logic        cin_i = 1'b0;
  logic [15:0] res_o;
  logic        cf_o, pf_o, af_o, zf_o, sf_o, of_o, wb_o;

  alu_sf_top dut (.*);

  always #5 clk_i = ~clk_i;

  typedef struct {
    logic [22:0] exp;
    string       tag;
  } item_t;

  item_t q[$];
  int n_run = 0, n_fail = 0;
  bit done = 0;

  // expected: {res[15:0], cf, pf, af, zf, sf, of, wb}
  function automatic logic [22:0] model(int op, bit word, int a, int b, bit cin);
    int w = word ? 16 : 8;
    int m = (1 << w) - 1;
    int h = 1 << (w - 1);
    int av = a & m, bv = b & m, r = 0, sa, sb, sr, ci;
    bit cf = 0, af = 0, of = 0, wb = 1, zf, sf, pf;
    logic [15:0] res;
    sa = (av >= h) ? av - (1 << w) : av;
    sb = (bv >= h) ? bv - (1 << w) : bv;
    case (op)
      0, 1: begin
        ci = (op == 1) ? int'(cin) : 0;
        r  = av + bv + ci;
        cf = r > m;
        af = ((av & 15) + (bv & 15) + ci) > 15;
        sr = sa + sb + ci;
        of = (sr >= h) || (sr < -h);
      end
      2, 3, 6: begin
        ci = (op == 3) ? int'(cin) : 0;
        r  = av - bv - ci;
        cf = r < 0;
        af = (av & 15) < ((bv & 15) + ci);
        sr = sa - sb - ci;
        of = (sr >= h) || (sr < -h);
        wb = (op != 6);
      end
      4: begin r = av + 1; cf = cin; af = (av & 15) == 15; of = (sa + 1) >= h; end
      5: begin r = av - 1; cf = cin; af = (av & 15) == 0;  of = (sa - 1) < -h; end
      7, 10: begin r = av & bv; wb = (op != 10); end
      8: r = av | bv;
      9: r = av ^ bv;
      default: return '0;
    endcase
    res = 16'(r & m);
    zf = (res == 0);
    sf = res[w-1];
    pf = ~^res[7:0];
    return {res, cf, pf, af, zf, sf, of, wb};
  endfunction

  task automatic send(int op, bit word, int a, int b, bit cin, string tag);
    item_t it;
    @(negedge clk_i);
    op_i = 4'(op); word_i = word; a_i = 16'(a); b_i = 16'(b); cin_i = cin;
    it.exp = model(op, word, a, b, cin);
    it.tag = tag;
    q.push_back(it);
  endtask

  // monitor: outputs of the registered stage are settled shortly after the edge
  initial begin
    forever begin
      @(posedge clk_i);
      #1;
      if (q.size() > 0) begin
        item_t it;
        logic [22:0] act;
        it  = q.pop_front();
        act = {res_o, cf_o, pf_o, af_o, zf_o, sf_o, of_o, wb_o};
        n_run++;
        if (act !== it.exp) begin
          n_fail++;
          $display("FAIL %s: act res=%h cpazso_wb=%b exp res=%h cpazso_wb=%b",
                   it.tag, act[22:7], act[6:0], it.exp[22:7], it.exp[6:0]);
        end
      end
    end
  end

  initial begin
    #2_000_000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: act timeout exp completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    op_i = 4'd0; a_i = 16'hFFFF; b_i = 16'hFFFF; word_i = 1'b1;
    #23;
    n_run++;  // R11 reset state
    if ({res_o, cf_o, pf_o, af_o, zf_o, sf_o, of_o, wb_o} !== '0) begin
      n_fail++;
      $display("FAIL R11: act %h exp 0", {res_o, cf_o, pf_o, af_o, zf_o, sf_o, of_o, wb_o});
    end
    rst_ni = 1'b1;

    send(0, 0, 'h00FF, 'h0001, 0, "R2");      // byte carry out, AF, ZF, PF
    send(0, 1, 'hFFFF, 'h0001, 0, "R2");      // word carry out
    send(2, 0, 'h0010, 'h0020, 0, "R2");      // byte borrow
    send(2, 1, 'h0100, 'h0200, 0, "R2");      // word borrow
    send(0, 0, 'h000F, 'h0001, 0, "R3");
    send(2, 1, 'h0010, 'h0001, 0, "R3");
    send(2, 1, 'h8000, 'h0000, 0, "R4");
    send(0, 0, 'h0080, 'h0080, 0, "R4");
    send(0, 1, 'h0100, 'h0200, 0, "R5");      // low byte zero, word nonzero
    send(0, 1, 'h0300, 'h0001, 0, "R5");
    send(0, 0, 'h007F, 'h0001, 0, "R6");
    send(2, 0, 'h0080, 'h0001, 0, "R6");
    send(0, 1, 'h7FFF, 'h0001, 0, "R6");
    send(2, 1, 'h7FFF, 'hFFFF, 0, "R6");
    send(4, 0, 'h00FF, 'h1234, 1, "R7");
    send(5, 0, 'h0000, 'h0000, 0, "R7");
    send(4, 1, 'h7FFF, 'h0000, 0, "R7");
    send(5, 1, 'h8000, 'h0000, 1, "R7");
    send(7, 1, 'hF0F0, 'h3C3C, 1, "R8");
    send(8, 0, 'h0012, 'h0081, 1, "R8");
    send(9, 1, 'hAAAA, 'hAAAA, 1, "R8");
    send(6, 1, 'h1234, 'h1234, 0, "R9");
    send(10, 0, 'h00F0, 'h000F, 1, "R9");
    send(0, 0, 'h12FF, 'h3401, 0, "R10");
    send(9, 0, 'hFF00, 'h0FFF, 0, "R10");
    send(1, 0, 'h00FE, 'h0001, 1, "R1");
    send(3, 1, 'h0000, 'h0000, 1, "R1");
    send(0, 0, 'h0050, 'h0020, 1, "R1");      // cin ignored by add
    send(13, 1, 'h1234, 'h5678, 1, "R12");
    send(11, 0, 'h0000, 'h0000, 0, "R12");
    for (int i = 0; i < 400; i++)
      send(int'($urandom_range(0, 12)), 1'($urandom), int'($urandom),
           int'($urandom), 1'($urandom), "R1");
    @(negedge clk_i);
    op_i = 4'd0;
    while (q.size() > 0) @(negedge clk_i);
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule